// File: doc/BRIEF.md
# R15 Operand Read Port Logic

This block supplies the three register operands of a data-processing instruction: the first ALU operand, the second operand that feeds the shifter, and the register that holds a shift count. The core keeps a 24-bit word-aligned program counter and the processor status bits together in register 15. When a register index other than 15 is selected, the block passes through the word read from the register file. When index 15 is selected, it returns the program counter advanced by the prefetch distance. The second operand also carries the status bits, while the first operand and the shift-count operand have every status bit cleared.

The prefetch distance depends on where the shift count comes from. With an immediate shift count, every port sees the instruction address plus 8. With a register shift count, the first and second operands see plus 12 and the shift-count port sees plus 8. The path is purely combinational and sits between the register file read ports and the shifter and ALU inputs.

Top module: `pc_operand_read`

## Requirements
- R1: For any index other than 15, each of the three outputs equals the register-file word on its own port, bit for bit.
- R2: When the first-operand index is 15, bits 31..26 and 1..0 of the first-operand output are zero, and bits 25..2 hold the advanced program counter.
- R3: When the shift-count index is 15, the shift-count output is the program counter plus 8 with all status bits zero, whether the shift count is immediate or from a register.
- R4: When the second-operand index is 15, bits 31..26 and 1..0 of its output equal the same bits of the R15 input: flags N Z C V at bits 31..28, interrupt masks at 27..26 and mode at 1..0.
- R5: With `amt_from_reg` low, the advanced program counter on the first and second operand ports is the R15 address field plus 8.
- R6: With `amt_from_reg` high, the advanced program counter on the first and second operand ports is the R15 address field plus 12.
- R7: The offset addition wraps within bits 25..2. For example, address field 0x3FFFFFC plus 8 gives 0x0000004, and no carry reaches the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_sel | input | 4 | First-operand register index |
| src_b_sel | input | 4 | Second-operand register index |
| amt_sel | input | 4 | Shift-count register index |
| amt_from_reg | input | 1 | High when the shift count comes from a register |
| src_a_rf | input | 32 | Register-file word for the first operand |
| src_b_rf | input | 32 | Register-file word for the second operand |
| amt_rf | input | 32 | Register-file word for the shift-count register |
| pcpsr | input | 32 | Current R15 contents (program counter and status bits) |
| src_a | output | 32 | First operand |
| src_b | output | 32 | Second operand |
| amt | output | 32 | Shift-count operand |

## Verification
The assertions assume that all inputs carry known values whenever they are evaluated, and they skip any evaluation in which an input is unknown. The cross-port checks assume that the ports selecting 15 all read the same R15 word. The stimulus drives every input to a defined value before the first sample. It selects index 15 on about one port in three, so that the pass-through and substitution paths and their combinations on several ports all occur, and the directed cases cover the all-ones R15 word at the address wrap.

// File: rtl/pc_operand_read.sv
module pc_operand_read #(
  parameter int IDX_W    = 4,
  parameter int PC_IDX   = 15,
  parameter int PC_LO    = 2,
  parameter int PC_HI    = 25,
  parameter int OFF_NEAR = 8,
  parameter int OFF_FAR  = 12
) (
  input  logic [IDX_W-1:0] src_a_sel,
  input  logic [IDX_W-1:0] src_b_sel,
  input  logic [IDX_W-1:0] amt_sel,
  input  logic             amt_from_reg,
  input  logic [31:0]      src_a_rf,
  input  logic [31:0]      src_b_rf,
  input  logic [31:0]      amt_rf,
  input  logic [31:0]      pcpsr,
  output logic [31:0]      src_a,
  output logic [31:0]      src_b,
  output logic [31:0]      amt
);
  localparam logic [31:0] PC_MASK =
    ((32'd1 << (PC_HI + 1)) - 32'd1) & ~((32'd1 << PC_LO) - 32'd1);
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

  logic [31:0] pc_near, pc_far, pc_ab, psr_bits;
  logic        a_pc, b_pc, s_pc;

  assign pc_near  = (pcpsr + 32'(OFF_NEAR)) & PC_MASK;
  assign pc_far   = (pcpsr + 32'(OFF_FAR)) & PC_MASK;
  assign pc_ab    = amt_from_reg ? pc_far : pc_near;
  assign psr_bits = pcpsr & ~PC_MASK;

  assign a_pc = (src_a_sel == PC_SEL);
  assign b_pc = (src_b_sel == PC_SEL);
  assign s_pc = (amt_sel == PC_SEL);

  assign src_a = a_pc ? pc_ab : src_a_rf;
  assign src_b = b_pc ? (pc_ab | psr_bits) : src_b_rf;
  assign amt   = s_pc ? pc_near : amt_rf;

  always_comb begin
    if (!$isunknown({src_a_sel, src_b_sel, amt_sel, amt_from_reg,
                     src_a_rf, src_b_rf, amt_rf, pcpsr})) begin
      // R1
      pass_through_chk: assert (a_pc || src_a == src_a_rf);
      // R2
      a_status_zero_chk: assert (!a_pc || (src_a & ~PC_MASK) == 32'd0);
      // R3
      amt_status_zero_chk: assert (!s_pc || (amt & ~PC_MASK) == 32'd0);
      // R3
      amt_near_chk: assert (!(s_pc && a_pc && !amt_from_reg) || amt == src_a);
      // R4
      b_status_merge_chk: assert (!b_pc || (src_b & ~PC_MASK) == psr_bits);
      // R5
      ab_same_pc_chk: assert (!(a_pc && b_pc) || src_a == (src_b & PC_MASK));
      // R6
      far_step_chk: assert (!(a_pc && s_pc && amt_from_reg) ||
                            src_a[PC_HI:PC_LO] == amt[PC_HI:PC_LO] + 1'b1);
    end
  end
endmodule

// File: tb/sim_pc_operand_read.sv
module sim_pc_operand_read;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  src_a_sel, src_b_sel, amt_sel;
  logic        amt_from_reg;
  logic [31:0] src_a_rf, src_b_rf, amt_rf, pcpsr;
  logic [31:0] src_a, src_b, amt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  pc_operand_read u0 (
    .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .amt_sel(amt_sel),
    .amt_from_reg(amt_from_reg), .src_a_rf(src_a_rf), .src_b_rf(src_b_rf),
    .amt_rf(amt_rf), .pcpsr(pcpsr), .src_a(src_a), .src_b(src_b), .amt(amt)
  );

  function automatic logic [31:0] pc_plus(input logic [31:0] r, input int off);
    logic [23:0] w;
    w = r[25:2] + 24'(off / 4);
    return {6'b0, w, 2'b0};
  endfunction

  function automatic logic [31:0] psr_of(input logic [31:0] r);
    return {r[31:26], 24'b0, r[1:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic [3:0] s,
                       input logic sr, input logic [31:0] r15);
    @(negedge clk);
    src_a_sel = a; src_b_sel = b; amt_sel = s; amt_from_reg = sr; pcpsr = r15;
    #1;
    if (a == 4'd15) chk(sr ? "R2 R6 src_a" : "R2 R5 src_a", src_a, pc_plus(r15, sr ? 12 : 8));
    else            chk("R1 src_a", src_a, src_a_rf);
    if (b == 4'd15) chk(sr ? "R4 R6 src_b" : "R4 R5 src_b", src_b,
                        pc_plus(r15, sr ? 12 : 8) | psr_of(r15));
    else            chk("R1 src_b", src_b, src_b_rf);
    if (s == 4'd15) chk("R3 amt", amt, pc_plus(r15, 8));
    else            chk("R1 amt", amt, amt_rf);
  endtask

  function automatic logic [3:0] pick_sel();
    return ($urandom % 3 == 0) ? 4'd15 : 4'($urandom % 15);
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    src_a_sel = 4'd0; src_b_sel = 4'd0; amt_sel = 4'd0; amt_from_reg = 1'b0;
    src_a_rf = 32'h1111_1111; src_b_rf = 32'h2222_2222; amt_rf = 32'h3333_3333;
    pcpsr = 32'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 idle src_a", src_a, 32'h1111_1111);
    chk("R1 idle src_b", src_b, 32'h2222_2222);
    chk("R1 idle amt", amt, 32'h3333_3333);

    // R7 wrap at the top of the address field
    apply(4'd15, 4'd15, 4'd15, 1'b0, 32'hFFFF_FFFF);
    chk("R7 wrap src_a", src_a, 32'h0000_0004);
    chk("R7 wrap src_b", src_b, 32'hFC00_0007);
    apply(4'd15, 4'd15, 4'd15, 1'b1, 32'hFFFF_FFFF);
    chk("R7 wrap far src_a", src_a, 32'h0000_0008);
    chk("R3 wrap amt", amt, 32'h0000_0004);
    // R4 status merged, R2 status cleared
    apply(4'd15, 4'd15, 4'd3, 1'b0, 32'hA800_1002);
    chk("R2 src_a", src_a, 32'h0000_1008);
    chk("R4 src_b", src_b, 32'hA800_100A);
    chk("R1 amt", amt, 32'h3333_3333);
    apply(4'd7, 4'd15, 4'd15, 1'b1, 32'h5400_0101);
    chk("R6 src_b", src_b, 32'h5400_010D);
    chk("R3 amt near", amt, 32'h0000_0108);

    for (int i = 0; i < 400; i++) begin
      src_a_rf = $urandom; src_b_rf = $urandom; amt_rf = $urandom;
      apply(pick_sel(), pick_sel(), pick_sel(), 1'($urandom), $urandom);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule